// File: doc/BRIEF.md
# Table-Based Constant Coefficient Multiplier

This block multiplies an unsigned input sample by a coefficient that is fixed when the design is elaborated. It does not use a general multiplier. The input word is cut into 4-bit digits, and each digit selects an entry from its own small table. Every table holds the sixteen multiples of the coefficient, from zero times up to fifteen times. The partial products that the tables return are moved to the weight of their digit and added to form the product. The tables are filled at elaboration by constant functions, so no memory initialisation and no loading at run time are needed.

The block is a two-stage pipeline: table lookup, then aligned addition. It takes one new sample in every clock with no stall. A valid flag travels beside the data, so a consumer only has to watch `valid_out`. When no sample is offered, the data registers keep their contents and the output word holds its last value. The reset is asynchronous and active low, and the block releases it internally in step with the clock.

Top module: `const_coef_mult`

## Requirements
- R1: While `rst_n` is low, `valid_out` is 0 and `y` is 0.
- R2: For every one of the 256 values of `x`, a sample accepted with `valid_in` high returns `y` equal to `x * COEF` exactly. `COEF` is an 8-bit unsigned parameter, and both operands are treated as unsigned.
- R3: `valid_out` is high exactly two clock cycles after the rising edge that sampled `valid_in` high. The product of that sample is on `y` in the same cycle.
- R4: A new sample can be accepted on every clock. Back-to-back samples give back-to-back results in the order they arrived, with no extra or lost results.
- R5: When `valid_in` is low, `x` is ignored. `valid_out` goes low two cycles later, and `y` keeps the last product for as long as `valid_out` stays low.
- R6: Bits `x[3:0]` select a table entry at weight 1, and bits `x[7:4]` select a table entry at weight 16. So `x = 8'h0F` gives `15*COEF` and `x = 8'hF0` gives `240*COEF`.
- R7: The extreme inputs are exact and do not wrap: `x = 8'h00` gives 0, and `x = 8'hFF` gives `255*COEF`, which always fits in 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| valid_in | input | 1 | Marks `x` as a sample to multiply in this cycle |
| x | input | 8 | Unsigned multiplicand |
| valid_out | output | 1 | Marks `y` as a new product |
| y | output | 16 | Unsigned product `x * COEF` |

## Verification
Each accepted sample is due on the outputs at the second rising edge after the edge that captured it. The driver records the product it expects together with the cycle in which that product should appear. The monitor samples on the falling edge and checks both the value and the cycle, so a result that comes early, late or out of order is reported. In idle cycles the driver puts changing values on `x`, and the monitor checks that `y` does not move while `valid_out` is low.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

  // Shift-and-add product of two small unsigned constants.
  // Used only at elaboration to fill the lookup tables.
  function automatic int unsigned ccm_multiple(input int unsigned coef,
                                               input int unsigned idx);
    int unsigned acc;
    acc = 0;
    for (int b = 0; b < 16; b++) begin
      if (idx[b]) acc = acc + (coef << b);
    end
    return acc;
  endfunction

endpackage

// File: rtl/ccm_rst_sync.sv
module ccm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ccm_digit_table.sv
module ccm_digit_table #(
  parameter int unsigned COEF   = 173,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned DEPTH = 1 << NIB_W,
  localparam int unsigned PP_W  = NIB_W + COEF_W
) (
  input  logic [NIB_W-1:0] digit,
  output logic [PP_W-1:0]  multiple
);

  logic [PP_W-1:0] entry [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int unsigned VAL = ccm_pkg::ccm_multiple(COEF, i);
    assign entry[i] = PP_W'(VAL);
  end

  assign multiple = entry[digit];

endmodule

// File: rtl/ccm_lookup_stage.sv
module ccm_lookup_stage #(
  parameter int unsigned COEF   = 173,
  parameter int unsigned IN_W   = 8,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned NUM_NIB = IN_W / NIB_W,
  localparam int unsigned PP_W    = NIB_W + COEF_W,
  localparam int unsigned PP_BUS  = NUM_NIB * PP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [IN_W-1:0]   x,
  output logic              valid_q,
  output logic [PP_BUS-1:0] pp_q
);

  logic [PP_BUS-1:0] pp_now;
  logic [PP_BUS-1:0] pp_d;
  logic              valid_d;

  for (genvar n = 0; n < NUM_NIB; n++) begin : g_digit
    ccm_digit_table #(
      .COEF   (COEF),
      .NIB_W  (NIB_W),
      .COEF_W (COEF_W)
    ) table_i (
      .digit    (x[n*NIB_W +: NIB_W]),
      .multiple (pp_now[n*PP_W +: PP_W])
    );
  end

  // Next state: data registers load only on an accepted sample.
  always_comb begin
    valid_d = valid_in;
    pp_d    = valid_in ? pp_now : pp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pp_q    <= '0;
    end else begin
      valid_q <= valid_d;
      pp_q    <= pp_d;
    end
  end

endmodule

// File: rtl/ccm_align_add.sv
module ccm_align_add #(
  parameter int unsigned NUM_NIB = 2,
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned PP_W    = 12,
  parameter int unsigned OUT_W   = 16,
  localparam int unsigned PP_BUS = NUM_NIB * PP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [PP_BUS-1:0] pp,
  output logic              valid_q,
  output logic [OUT_W-1:0]  y_q
);

  logic [OUT_W-1:0] sum;
  logic [OUT_W-1:0] y_d;
  logic             valid_d;

  // Each partial product is moved to the weight of its digit.
  always_comb begin
    sum = '0;
    for (int n = 0; n < NUM_NIB; n++) begin
      sum = sum + (OUT_W'(pp[n*PP_W +: PP_W]) << (n * NIB_W));
    end
  end

  always_comb begin
    valid_d = valid_in;
    y_d     = valid_in ? sum : y_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      y_q     <= '0;
    end else begin
      valid_q <= valid_d;
      y_q     <= y_d;
    end
  end

endmodule

// File: rtl/const_coef_mult.sv
module const_coef_mult #(
  parameter int unsigned COEF   = 173,
  parameter int unsigned IN_W   = 8,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned NUM_NIB = IN_W / NIB_W,
  localparam int unsigned PP_W    = NIB_W + COEF_W,
  localparam int unsigned PP_BUS  = NUM_NIB * PP_W,
  localparam int unsigned OUT_W   = IN_W + COEF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [IN_W-1:0]  x,
  output logic             valid_out,
  output logic [OUT_W-1:0] y
);

  logic              rst_core_n;
  logic              valid_s1;
  logic [PP_BUS-1:0] pp_s1;

  ccm_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ccm_lookup_stage #(
    .COEF   (COEF),
    .IN_W   (IN_W),
    .NIB_W  (NIB_W),
    .COEF_W (COEF_W)
  ) lookup_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .valid_in (valid_in),
    .x        (x),
    .valid_q  (valid_s1),
    .pp_q     (pp_s1)
  );

  ccm_align_add #(
    .NUM_NIB (NUM_NIB),
    .NIB_W   (NIB_W),
    .PP_W    (PP_W),
    .OUT_W   (OUT_W)
  ) add_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .valid_in (valid_s1),
    .pp       (pp_s1),
    .valid_q  (valid_out),
    .y_q      (y)
  );

endmodule

// File: rtl/const_coef_mult_chk.sv
module const_coef_mult_chk #(
  parameter int unsigned COEF   = 173,
  parameter int unsigned IN_W   = 8,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned OUT_W = IN_W + COEF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_core_n,
  input logic             valid_in,
  input logic [IN_W-1:0]  x,
  input logic             valid_out,
  input logic [OUT_W-1:0] y
);

  localparam logic [OUT_W-1:0] K_EXT  = OUT_W'(COEF);
  localparam logic [OUT_W-1:0] X_MAX  = OUT_W'((1 << IN_W) - 1);

  logic [1:0]       since_rst;
  logic [OUT_W-1:0] x_ext;

  assign x_ext = OUT_W'(x);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)           since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!valid_out && y == '0);
    end
  end

  // R2: product equals input times coefficient
  assert_product_exact_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (since_rst >= 2'd2 && valid_out) |-> (y == K_EXT * $past(x_ext, 2)));

  // R3: valid flag trails the input flag by two cycles
  assert_latency_two_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (since_rst >= 2'd2) |-> (valid_out == $past(valid_in, 2)));

  // R5: output held while no new product
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (since_rst >= 2'd1 && !valid_out) |-> $stable(y));

  // R7: output never exceeds the largest product
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    valid_out |-> (y <= K_EXT * X_MAX));

endmodule

bind const_coef_mult const_coef_mult_chk #(
  .COEF   (COEF),
  .IN_W   (IN_W),
  .COEF_W (COEF_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_core_n (rst_core_n),
  .valid_in   (valid_in),
  .x          (x),
  .valid_out  (valid_out),
  .y          (y)
);

// File: tb/const_coef_mult_tb_top.sv
`timescale 1ns/100ps
module const_coef_mult_tb_top;

  localparam int unsigned COEF = 173;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_in;
  logic [7:0]  x;
  logic        valid_out;
  logic [15:0] y;

  const_coef_mult #(.COEF(COEF)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .x         (x),
    .valid_out (valid_out),
    .y         (y)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  bit    mon_en = 1'b0;
  logic [15:0] prev_y = '0;

  int    exp_q[$];
  int    due_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Driver: offer one sample and record its expected product and due cycle.
  task automatic send(input int v, input string tag);
    @(negedge clk);
    x        = v[7:0];
    valid_in = 1'b1;
    exp_q.push_back((v * COEF) & 16'hFFFF);
    due_q.push_back(cyc + 2);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int junk);
    @(negedge clk);
    valid_in = 1'b0;
    x        = junk[7:0];
  endtask

  // Monitor: pops the scoreboard whenever a product appears.
  always @(negedge clk) begin
    if (mon_en) begin
      if (valid_out) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected result", int'(y), -1);
        end else begin
          int    e;
          int    d;
          string t;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          t = tag_q.pop_front();
          check(y == e[15:0], t, int'(y), e);
          check(cyc == d, "R3 result cycle", cyc, d);
        end
      end else begin
        check(y == prev_y, "R5 hold while idle", int'(y), int'(prev_y));
      end
      prev_y = y;
    end
  end

  initial begin
    rst_n    = 1'b0;
    valid_in = 1'b0;
    x        = 8'h00;
    repeat (3) @(negedge clk);
    check(valid_out == 1'b0, "R1 valid_out in reset", int'(valid_out), 0);
    check(y == 16'h0, "R1 y in reset", int'(y), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(valid_out == 1'b0, "R1 valid_out after release", int'(valid_out), 0);
    mon_en = 1'b1;

    // R6 digit weights and R7 extremes
    send(8'h0F, "R6 low digit");
    send(8'hF0, "R6 high digit");
    send(8'h00, "R7 zero input");
    send(8'hFF, "R7 max input");
    send(8'h01, "R6 unit input");
    send(8'h10, "R6 high unit input");

    // R5: idle with changing x
    for (int i = 0; i < 6; i++) idle(8'hA5 ^ (i * 37));

    // R2 and R4: full back-to-back sweep
    for (int v = 0; v < 256; v++) send(v, "R2 sweep");

    // R5 and R4: alternating valid pattern
    for (int v = 0; v < 40; v++) begin
      send((v * 29 + 7) & 8'hFF, "R4 gapped");
      idle(v * 13);
      if (v % 3 == 0) idle(8'hFF - v);
    end

    for (int i = 0; i < 6; i++) idle(i * 91);
    check(exp_q.size() == 0, "R4 all results delivered", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    wait (done || cyc >= WD_LIMIT);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule